// File: doc/BRIEF.md
# Oversampling Two-Bit Video Capture

This block turns a two-wire digital video stream into bytes for a frame buffer. The stream carries two video bits per dot at a fixed dot rate, and the block's sample clock runs at four times that rate. Each video wire is sampled four times per dot into its own 16-sample shift register. A programmable voter then reduces each group of four samples to one pixel bit, using the number of ones in the group.

Horizontal and vertical sync are first brought into the sample-clock domain. A falling edge on horizontal sync starts a line. Every 16 samples, which is four dots, the block latches one data byte and its frame-buffer address and then pulses a write strobe. The row count restarts at each vertical sync. Rows numbered 256 and above never produce a write, so lines beyond the visible frame cannot overwrite stored data. The memory that takes the bytes, the clocking and any display path sit outside the block.

Top module: `video_capture`

## Requirements
- R1: `hsync_i` and `vsync_i` each pass through two synchronizer flops. A line starts on the falling edge of the synchronized `hsync_i`. The first clock edge that sees `hsync_i` low is edge H, the sample counter is cleared at edge H+2, and under rising-edge sampling sample 0 of the line is the video value captured at edge H+1.
- R2: Each video bit is sampled four times per dot, and a byte window holds 16 consecutive samples. Pixel p (0..3) of a window is decided from samples 4p..4p+3 of that window.
- R3: A pixel bit is 0 when all four of its samples are 0. When n of the four samples are 1 (n = 1..4), the pixel bit is `cfg_i[n-1]`.
- R4: `cfg_i[4]` selects the sampling edge for `v1_i` and `cfg_i[5]` selects it for `v2_i`, with 1 meaning the rising edge and 0 the falling edge. A value driven between a rising edge and the next falling edge enters the falling-edge stream one sample earlier than it enters the rising-edge stream.
- R5: The byte layout is: bits 7..6 hold pixel 1, bits 5..4 pixel 0, bits 3..2 pixel 3 and bits 1..0 pixel 2. Within each pair the upper bit comes from `v2_i` and the lower bit from `v1_i`.
- R6: `addr_o[14:7]` is the low eight bits of the row count. `addr_o[6:0]` is the byte index within the line, which equals the sample count divided by 16.
- R7: `data_o` and `addr_o` update at the edge where the sample count is 16b+15. `we_o` rises at the edge where the count's low four bits are next 1 and falls where they are 14. It therefore stays high for 13 cycles while data and address hold still.
- R8: While the synchronized `vsync_i` is high, the row count is held at 511. Every line start increments the row count, so the first line after vertical sync is row 0.
- R9: A line whose row count is 256 or more produces no write.
- R10: Each line yields exactly 128 writes. After the last one, no write occurs until the next line start, however long the line runs. No write occurs between reset and the first line start.
- R11: A line start cancels any pending write and drops `we_o`. A line shorter than 19 samples therefore produces no write.
- R12: After reset, `we_o`, `data_o` and `addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock, four times the dot rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync; a falling edge starts a line |
| vsync_i | input | 1 | Vertical sync; high holds the row count at 511 |
| v1_i | input | 1 | Video bit 1, the lower bit of each pixel |
| v2_i | input | 1 | Video bit 2, the upper bit of each pixel |
| cfg_i | input | 6 | [3:0] vote enables for 1 to 4 ones; [4] edge select for v1_i; [5] edge select for v2_i |
| addr_o | output | 15 | Frame-buffer address, {row, byte index} |
| data_o | output | 8 | Four packed 2-bit pixels |
| we_o | output | 1 | Write strobe |

## Verification
Each line is counted in steps, where step j is driven just after rising edge H0+j and `hsync_i` falls at step 0. Sample k of the line is then the value driven at step k+1 under rising-edge sampling, or at step k+2 under falling-edge sampling. The bench predicts that byte b's data and address appear from step 16b+19 and that `we_o` is high on steps 16b+21 through 16b+33. It samples every output on the falling edge of each step and compares each one against that arithmetic. This covers full lines for eight vote and edge settings, a very long line, a run of 18-step lines, rows 255 and 256, and a line just after a vertical sync.

// File: rtl/vcap_pkg.sv
`timescale 1ns/1ps
package vcap_pkg;
  localparam int unsigned DEF_OSR  = 4;
  localparam int unsigned DEF_PPB  = 4;
  localparam int unsigned DEF_DOTS = 512;
  localparam int unsigned DEF_ROWS = 256;
  localparam int unsigned NCH      = 2;

  // byte slot (from MSB) that holds pixel p: pairs swapped inside each nibble
  function automatic int unsigned pix_slot(input int unsigned p);
    return p ^ 1;
  endfunction
endpackage

// File: rtl/vcap_sync.sv
`timescale 1ns/1ps
module vcap_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/vcap_sampler.sv
`timescale 1ns/1ps
module vcap_sampler #(
  parameter int unsigned SREG_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vid_i,
  input  logic              rise_sel_i,
  output logic [SREG_W-1:0] sreg_o
);
  logic rise_q, fall_q;
  logic [SREG_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= 1'b0;
    else         rise_q <= vid_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= vid_i;
  end

  // oldest sample ends up at the MSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg_q <= '0;
    else         sreg_q <= {sreg_q[SREG_W-2:0], rise_sel_i ? rise_q : fall_q};
  end

  assign sreg_o = sreg_q;
endmodule

// File: rtl/vcap_voter.sv
`timescale 1ns/1ps
module vcap_voter #(
  parameter int unsigned OSR = 4
) (
  input  logic [OSR-1:0] smp_i,
  input  logic [OSR-1:0] en_i,
  output logic           bit_o
);
  localparam int unsigned CNT_W = $clog2(OSR + 1);

  logic [CNT_W-1:0] ones;
  logic [OSR:0]     tbl;

  assign tbl = {en_i, 1'b0};

  always_comb begin
    ones = '0;
    for (int i = 0; i < OSR; i++) ones = ones + CNT_W'(smp_i[i]);
  end

  assign bit_o = tbl[ones];
endmodule

// File: rtl/vcap_line_ctrl.sv
`timescale 1ns/1ps
module vcap_line_ctrl #(
  parameter int unsigned SREG_W   = 16,
  parameter int unsigned LINE_SMP = 2048,
  parameter int unsigned ROW_W    = 8,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      line_start_i,
  input  logic                      frame_clr_i,
  input  logic [DATA_W-1:0]         byte_i,
  output logic [ROW_W+$clog2(LINE_SMP/SREG_W)-1:0] addr_o,
  output logic [DATA_W-1:0]         data_o,
  output logic                      we_o,
  output logic [ROW_W:0]            row_o
);
  localparam int unsigned NIB_W  = $clog2(SREG_W);
  localparam int unsigned HC_W   = $clog2(LINE_SMP) + 1;
  localparam int unsigned COL_W  = HC_W - 1 - NIB_W;
  localparam int unsigned ADDR_W = ROW_W + COL_W;

  logic [HC_W-1:0]   hcnt_q;
  logic [ROW_W:0]    row_q;
  logic              pend_q, we_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NIB_W-1:0]  nib;
  logic              in_line, latch_now, we_on, we_off;

  assign nib       = hcnt_q[NIB_W-1:0];
  assign in_line   = ~hcnt_q[HC_W-1];
  assign latch_now = in_line && (nib == '1);
  assign we_on     = (nib == NIB_W'(1));
  assign we_off    = (nib == NIB_W'(SREG_W - 2));

  // horizontal sample counter, parks at all ones
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hcnt_q <= '1;
    else if (line_start_i)      hcnt_q <= '0;
    else if (hcnt_q != '1)      hcnt_q <= hcnt_q + HC_W'(1);
  end

  // row counter: all ones during vertical sync, so first line lands on 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           row_q <= '1;
    else if (frame_clr_i)  row_q <= '1;
    else if (line_start_i) row_q <= row_q + (ROW_W+1)'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      addr_q <= '0;
    end else if (!line_start_i && latch_now) begin
      data_q <= byte_i;
      addr_q <= {row_q[ROW_W-1:0], hcnt_q[HC_W-2:NIB_W]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      we_q   <= 1'b0;
    end else if (line_start_i) begin
      pend_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      if (latch_now)   pend_q <= ~row_q[ROW_W];
      else if (we_on)  pend_q <= 1'b0;
      if (we_on)       we_q <= pend_q;
      else if (we_off) we_q <= 1'b0;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign we_o   = we_q;
  assign row_o  = row_q;
endmodule

// File: rtl/video_capture.sv
`timescale 1ns/1ps
module video_capture #(
  parameter int unsigned OSR  = vcap_pkg::DEF_OSR,
  parameter int unsigned PPB  = vcap_pkg::DEF_PPB,
  parameter int unsigned DOTS = vcap_pkg::DEF_DOTS,
  parameter int unsigned ROWS = vcap_pkg::DEF_ROWS,
  localparam int unsigned NCH    = vcap_pkg::NCH,
  localparam int unsigned SREG_W = OSR * PPB,
  localparam int unsigned DATA_W = NCH * PPB,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned COL_W  = $clog2(DOTS / PPB),
  localparam int unsigned ADDR_W = ROW_W + COL_W,
  localparam int unsigned CFG_W  = OSR + NCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsync_i,
  input  logic              vsync_i,
  input  logic              v1_i,
  input  logic              v2_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              we_o
);
  localparam int unsigned LINE_SMP = DOTS * OSR;

  logic [1:0]        sync_q;
  logic              hs_d_q, line_start;
  logic [NCH-1:0]    vid;
  logic [DATA_W-1:0] byte_w;
  logic [ROW_W:0]    row_q;

  vcap_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({vsync_i, hsync_i}),
    .q_o   (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hs_d_q <= 1'b1;
    else         hs_d_q <= sync_q[0];
  end

  assign line_start = hs_d_q & ~sync_q[0];
  assign vid        = {v2_i, v1_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SREG_W-1:0] sreg;

    vcap_sampler #(.SREG_W(SREG_W)) u_smp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .vid_i     (vid[c]),
      .rise_sel_i(cfg_i[OSR+c]),
      .sreg_o    (sreg)
    );

    for (genvar p = 0; p < PPB; p++) begin : g_pix
      localparam int unsigned SLOT = vcap_pkg::pix_slot(p);
      localparam int unsigned BIDX = DATA_W - NCH*(SLOT+1) + c;

      vcap_voter #(.OSR(OSR)) u_vote (
        .smp_i(sreg[SREG_W-1-OSR*p -: OSR]),
        .en_i (cfg_i[OSR-1:0]),
        .bit_o(byte_w[BIDX])
      );
    end
  end

  vcap_line_ctrl #(
    .SREG_W  (SREG_W),
    .LINE_SMP(LINE_SMP),
    .ROW_W   (ROW_W),
    .DATA_W  (DATA_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_start_i(line_start),
    .frame_clr_i (sync_q[1]),
    .byte_i      (byte_w),
    .addr_o      (addr_o),
    .data_o      (data_o),
    .we_o        (we_o),
    .row_o       (row_q)
  );
endmodule

// File: rtl/video_capture_chk.sv
`timescale 1ns/1ps
module video_capture_chk #(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned SREG_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vsync_i,
  input logic              we_o,
  input logic [DATA_W-1:0] data_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ROW_W:0]    row_q,
  input logic              line_start
);
  localparam int unsigned WE_LEN = SREG_W - 3;

  logic [5:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   run_q <= '0;
    else if (we_o) run_q <= run_q + 6'd1;
    else           run_q <= '0;
  end

  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && $past(we_o)) |-> ($stable(data_o) && $stable(addr_o)));

  assert_we_max_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (run_q < 6'(WE_LEN)));

  assert_we_full_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(we_o) && !$past(line_start)) |-> (run_q == 6'(WE_LEN)));

  assert_vsync_row_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vsync_i, 3) |-> (row_q == '1));

  assert_start_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start |=> !we_o);
endmodule

bind video_capture video_capture_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vsync_i   (vsync_i),
  .we_o      (we_o),
  .data_o    (data_o),
  .addr_o    (addr_o),
  .row_q     (row_q),
  .line_start(line_start)
);

// File: tb/tb_video_capture.sv
`timescale 1ns/1ps
module tb_video_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsync_i = 1'b1;
  logic        vsync_i = 1'b0;
  logic        v1_i = 1'b0;
  logic        v2_i = 1'b0;
  logic [5:0]  cfg_i = 6'b111100;
  logic [14:0] addr_o;
  logic [7:0]  data_o;
  logic        we_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_row = 511;

  video_capture dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hsync_i(hsync_i),
    .vsync_i(vsync_i),
    .v1_i   (v1_i),
    .v2_i   (v2_i),
    .cfg_i  (cfg_i),
    .addr_o (addr_o),
    .data_o (data_o),
    .we_o   (we_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // sample stream: pixel p carries a 4-sample nibble, first sample at the MSB
  function automatic int samp(input int c, input int k);
    int p, nib;
    if (k < 0) return 0;
    p = k / 4;
    if (p >= 512) return 0;
    nib = (c == 1) ? ((p * 7 + 3) % 16) : (p % 16);
    return (nib >> (3 - (k % 4))) & 1;
  endfunction

  function automatic logic [7:0] exp_byte(input int b);
    logic [7:0] r;
    r = '0;
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 2; c++) begin
        int n;
        logic v;
        n = 0;
        for (int s = 0; s < 4; s++) begin
          int k;
          k = 16 * b + 4 * p + s;
          n += cfg_i[4 + c] ? samp(c, k) : samp(c, k + 1);
        end
        v = (n == 0) ? 1'b0 : cfg_i[n - 1];
        r[7 - 2 * (p ^ 1) - (1 - c)] = v;
      end
    end
    return r;
  endfunction

  task automatic run_line(input int len, input string tag);
    exp_row = (exp_row + 1) % 512;
    for (int j = 0; j < len; j++) begin
      logic ew;
      int b;
      @(posedge clk_i);
      #2;
      hsync_i = (j < 8) ? 1'b0 : 1'b1;
      v1_i = samp(0, j - 1) != 0;
      v2_i = samp(1, j - 1) != 0;
      @(negedge clk_i);
      b  = (j - 21) / 16;
      ew = (exp_row < 256) && (j >= 21) && (((j - 21) % 16) <= 12) && (b <= 127);
      chk({tag, " we"}, {31'd0, we_o}, {31'd0, ew});
      if (ew) begin
        chk({tag, " data"}, {24'd0, data_o}, {24'd0, exp_byte(b)});
        chk({tag, " addr R6"}, {17'd0, addr_o}, {17'd0, exp_row[7:0], b[6:0]});
      end
    end
  endtask

  task automatic vsync_pulse();
    for (int j = 0; j < 12; j++) begin
      @(posedge clk_i);
      #2;
      vsync_i = (j < 6);
      @(negedge clk_i);
      chk("R8 vsync no write", {31'd0, we_o}, 32'd0);
    end
    exp_row = 511;
  endtask

  initial begin
    logic [5:0] cfgs [8];
    string      tags [8];
    cfgs[0] = 6'b111100; tags[0] = "R1 R2 R3 R5 R7 best vote";
    cfgs[1] = 6'b111111; tags[1] = "R3 any one";
    cfgs[2] = 6'b110000; tags[2] = "R3 none";
    cfgs[3] = 6'b110101; tags[3] = "R3 odd counts";
    cfgs[4] = 6'b111010; tags[4] = "R3 even counts";
    cfgs[5] = 6'b001100; tags[5] = "R4 both falling";
    cfgs[6] = 6'b101100; tags[6] = "R4 v1 falling";
    cfgs[7] = 6'b011110; tags[7] = "R4 v2 falling";

    repeat (3) @(negedge clk_i);
    chk("R12 reset we", {31'd0, we_o}, 32'd0);
    chk("R12 reset data", {24'd0, data_o}, 32'd0);
    chk("R12 reset addr", {17'd0, addr_o}, 32'd0);
    @(posedge clk_i);
    #2 rst_ni = 1'b1;

    for (int j = 0; j < 40; j++) begin
      @(negedge clk_i);
      chk("R10 idle before first line", {31'd0, we_o}, 32'd0);
    end

    vsync_pulse();
    for (int i = 0; i < 8; i++) begin
      cfg_i = cfgs[i];
      run_line(2080, tags[i]);
    end

    cfg_i = 6'b111100;
    run_line(4200, "R10 long line");
    for (int i = 0; i < 246; i++) run_line(18, "R11 short line");
    run_line(2080, "R6 row 255");
    run_line(2080, "R9 row 256");
    vsync_pulse();
    run_line(2080, "R8 first row after vsync");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog (all requirements) act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule